// File: doc/BRIEF.md
# Banked Memory Address Translator

This block turns a 16-bit processor address into a target and a physical location in a two-bank RAM system. Three inputs steer it: a configuration word that picks ROM or RAM for each upper region and selects the RAM bank, a RAM-configuration word that defines common areas at the top and bottom of memory, and two page pointers. Each pointer holds a bank bit and a page number, and the translator moves the processor's zero page and stack page to the page that pointer names.

Each cycle the block asserts exactly one of six target selects: system ROM, internal function ROM, external function ROM, I/O, RAM or the register window. For RAM accesses it also drives a 17-bit physical address, and the top bit of that address is the bank. The whole mapping is combinational. A parameter adds an output register, which gives one cycle of latency. The surrounding memory controller uses the selects to pick a device and the physical address to index DRAM.

Top module: `bank_xlate`

## Requirements
- R1: After reset, exactly one of the six select outputs is high in every cycle.
- R2: While reset is held, sel_ram is 1 and phys_addr is 0. With REG_OUT=1, the outputs show the translation of the inputs applied one clock earlier.
- R3: Addresses 0xFF00 to 0xFF04 assert sel_regs for any configuration. 0xFF05 decodes as part of the high region.
- R4: Addresses 0xD000 to 0xDFFF assert sel_io when cfg_word[0] is 0. When cfg_word[0] is 1, they decode as part of the high region.
- R5: The high region (0xC000 to 0xFFFF) is set by cfg_word[5:4] and the mid region (0x8000 to 0xBFFF) by cfg_word[3:2]. Code 00 selects system ROM, 01 internal function ROM, 10 external function ROM and 11 RAM.
- R6: The low region (0x4000 to 0x7FFF) selects system ROM when cfg_word[1] is 0 and RAM when it is 1. Addresses 0x0000 to 0x3FFF always select RAM.
- R7: A RAM access drives phys_addr = {bank, cpu_addr}, where the bank is cfg_word[6]. Every other select drives phys_addr = {0, cpu_addr}.
- R8: ramcfg_word[1:0] sets the common-area size: 00 = 1 KiB, 01 = 4 KiB, 10 = 8 KiB, 11 = 16 KiB. ramcfg_word[2] enables the area at the bottom of memory and ramcfg_word[3] the area at the top. A RAM access inside an enabled area uses bank 0.
- R9: A RAM access to page 0x00 drives phys_addr = {pg0_ptr, cpu_addr[7:0]}, and page 0x01 uses pg1_ptr in the same way. Pointer bit 8 is the bank and bits 7:0 are the page. Neither the bank bit nor the common areas affect this.
- R10: Any other RAM access resolves to a bank and page first, with the common areas applied. If that {bank, page} equals pg0_ptr, the access goes to page 0x00 of the same bank. If it equals pg1_ptr, it goes to page 0x01. pg0_ptr wins when both match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | Processor address |
| cfg_word | input | 8 | Region overlay, I/O enable and bank select |
| ramcfg_word | input | 8 | Common-area enables and size |
| pg0_ptr | input | 9 | Zero-page target {bank, page} |
| pg1_ptr | input | 9 | Stack-page target {bank, page} |
| phys_addr | output | 17 | Physical address, bit 16 is the bank |
| sel_sysrom | output | 1 | System ROM select |
| sel_fnrom_int | output | 1 | Internal function ROM select |
| sel_fnrom_ext | output | 1 | External function ROM select |
| sel_io | output | 1 | I/O select |
| sel_ram | output | 1 | RAM select |
| sel_regs | output | 1 | Register window select |

## Verification
The hardest case to reach is the swap-back path. For it, three things must hold at once: the bank select, the common-area settings and a pointer value must all line up with an ordinary RAM address outside pages 0 and 1. The stimulus moves pg0_ptr to a page in bank 1 and then reads that page with the bank bit set and cleared. It also points pg1_ptr into the mid region with that region mapped to RAM. A further case turns on a bottom common area, checks that zero-page redirection still wins over it, and then checks a pointer match that the common area created.

// File: rtl/bmx_pkg.sv
package bmx_pkg;
    localparam int CPU_AW  = 16;
    localparam int PAGE_W  = 8;
    localparam int BANK_W  = 1;
    localparam int PTR_W   = BANK_W + PAGE_W;
    localparam int PHYS_AW = CPU_AW + BANK_W;
    localparam int CFG_W   = 8;
    localparam int NSEL    = 6;

    // select vector bit positions
    localparam int SEL_SYSROM = 0;
    localparam int SEL_FNINT  = 1;
    localparam int SEL_FNEXT  = 2;
    localparam int SEL_IO     = 3;
    localparam int SEL_RAM    = 4;
    localparam int SEL_REGS   = 5;

    // region bounds
    localparam logic [CPU_AW-1:0] LO_BASE  = 16'h4000;
    localparam logic [CPU_AW-1:0] MID_BASE = 16'h8000;
    localparam logic [CPU_AW-1:0] HI_BASE  = 16'hC000;
    localparam logic [CPU_AW-1:0] IO_BASE  = 16'hD000;
    localparam logic [CPU_AW-1:0] IO_LAST  = 16'hDFFF;
    localparam logic [CPU_AW-1:0] REG_BASE = 16'hFF00;
    localparam logic [CPU_AW-1:0] REG_LAST = 16'hFF04;

    // configuration word fields
    localparam int CFG_IO_BIT   = 0;
    localparam int CFG_LO_BIT   = 1;
    localparam int CFG_MID_LSB  = 2;
    localparam int CFG_HI_LSB   = 4;
    localparam int CFG_BANK_BIT = 6;

    // RAM-configuration word fields
    localparam int RC_SZ_LSB  = 0;
    localparam int RC_BOT_BIT = 2;
    localparam int RC_TOP_BIT = 3;

    typedef struct packed {
        logic [NSEL-1:0]    sel;
        logic [PHYS_AW-1:0] phys;
    } xlate_s;

    function automatic logic [CPU_AW:0] share_bytes(input logic [1:0] code);
        logic [CPU_AW:0] n;
        case (code)
            2'b00:   n = (CPU_AW+1)'(1024);
            2'b01:   n = (CPU_AW+1)'(4096);
            2'b10:   n = (CPU_AW+1)'(8192);
            default: n = (CPU_AW+1)'(16384);
        endcase
        return n;
    endfunction
endpackage

// File: rtl/bmx_region_decode.sv
module bmx_region_decode
    import bmx_pkg::*;
(
    input  logic [CPU_AW-1:0] addr,
    input  logic [CFG_W-1:0]  cfg,
    output logic [NSEL-1:0]   sel
);
    logic [1:0] field_code;
    logic       in_regs;
    logic       in_io;

    assign in_regs = (addr >= REG_BASE) && (addr <= REG_LAST);
    assign in_io   = (addr >= IO_BASE) && (addr <= IO_LAST) && !cfg[CFG_IO_BIT];

    // overlay code for the region the address falls in; 11 means RAM
    always_comb begin
        if (addr >= HI_BASE)
            field_code = cfg[CFG_HI_LSB +: 2];
        else if (addr >= MID_BASE)
            field_code = cfg[CFG_MID_LSB +: 2];
        else if (addr >= LO_BASE)
            field_code = {2{cfg[CFG_LO_BIT]}};
        else
            field_code = 2'b11;
    end

    always_comb begin
        sel = '0;
        if (in_regs) begin
            sel[SEL_REGS] = 1'b1;
        end else if (in_io) begin
            sel[SEL_IO] = 1'b1;
        end else begin
            case (field_code)
                2'b00:   sel[SEL_SYSROM] = 1'b1;
                2'b01:   sel[SEL_FNINT]  = 1'b1;
                2'b10:   sel[SEL_FNEXT]  = 1'b1;
                default: sel[SEL_RAM]    = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/bmx_shared_window.sv
module bmx_shared_window
    import bmx_pkg::*;
(
    input  logic [CPU_AW-1:0] addr,
    input  logic [CFG_W-1:0]  ramcfg,
    output logic              in_bottom,
    output logic              in_top,
    output logic              force_bank0
);
    localparam logic [CPU_AW:0] SPACE = (CPU_AW+1)'(1) << CPU_AW;

    logic [CPU_AW:0] span;
    logic [CPU_AW:0] addr_x;

    assign span   = share_bytes(ramcfg[RC_SZ_LSB +: 2]);
    assign addr_x = {1'b0, addr};

    always_comb begin
        in_bottom   = ramcfg[RC_BOT_BIT] && (addr_x < span);
        in_top      = ramcfg[RC_TOP_BIT] && (addr_x >= (SPACE - span));
        force_bank0 = in_bottom || in_top;
    end
endmodule

// File: rtl/bmx_ram_map.sv
module bmx_ram_map
    import bmx_pkg::*;
(
    input  logic [CPU_AW-1:0]  addr,
    input  logic               bank_sel,
    input  logic               force_bank0,
    input  logic [PTR_W-1:0]   pg0_ptr,
    input  logic [PTR_W-1:0]   pg1_ptr,
    output logic [PHYS_AW-1:0] phys
);
    localparam logic [PAGE_W-1:0] ZP_PAGE = '0;
    localparam logic [PAGE_W-1:0] SP_PAGE = PAGE_W'(1);

    logic [PAGE_W-1:0] page;
    logic [PAGE_W-1:0] offs;
    logic              bank;
    logic [PTR_W-1:0]  target;

    assign page   = addr[CPU_AW-1 -: PAGE_W];
    assign offs   = addr[PAGE_W-1:0];
    assign bank   = force_bank0 ? 1'b0 : bank_sel;
    assign target = {bank, page};

    always_comb begin
        if (page == ZP_PAGE)
            phys = {pg0_ptr, offs};
        else if (page == SP_PAGE)
            phys = {pg1_ptr, offs};
        else if (target == pg0_ptr)
            phys = {bank, ZP_PAGE, offs};
        else if (target == pg1_ptr)
            phys = {bank, SP_PAGE, offs};
        else
            phys = {target, offs};
    end
endmodule

// File: rtl/bank_xlate.sv
module bank_xlate
    import bmx_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CPU_AW-1:0]  cpu_addr,
    input  logic [CFG_W-1:0]   cfg_word,
    input  logic [CFG_W-1:0]   ramcfg_word,
    input  logic [PTR_W-1:0]   pg0_ptr,
    input  logic [PTR_W-1:0]   pg1_ptr,
    output logic [PHYS_AW-1:0] phys_addr,
    output logic               sel_sysrom,
    output logic               sel_fnrom_int,
    output logic               sel_fnrom_ext,
    output logic               sel_io,
    output logic               sel_ram,
    output logic               sel_regs
);
    localparam xlate_s RESET_VAL = '{sel: NSEL'(1) << SEL_RAM, phys: '0};

    logic [NSEL-1:0]    region_sel;
    logic               in_bottom;
    logic               in_top;
    logic               force_bank0;
    logic [PHYS_AW-1:0] ram_phys;
    xlate_s             result_d;
    xlate_s             result_q;

    bmx_region_decode u_region (
        .addr (cpu_addr),
        .cfg  (cfg_word),
        .sel  (region_sel)
    );

    bmx_shared_window u_shared (
        .addr        (cpu_addr),
        .ramcfg      (ramcfg_word),
        .in_bottom   (in_bottom),
        .in_top      (in_top),
        .force_bank0 (force_bank0)
    );

    bmx_ram_map u_map (
        .addr        (cpu_addr),
        .bank_sel    (cfg_word[CFG_BANK_BIT]),
        .force_bank0 (force_bank0),
        .pg0_ptr     (pg0_ptr),
        .pg1_ptr     (pg1_ptr),
        .phys        (ram_phys)
    );

    always_comb begin
        result_d.sel  = region_sel;
        result_d.phys = region_sel[SEL_RAM] ? ram_phys : {{BANK_W{1'b0}}, cpu_addr};
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) result_q <= RESET_VAL;
                else        result_q <= result_d;
            end
        end else begin : g_comb
            assign result_q = result_d;
        end
    endgenerate

    assign phys_addr     = result_q.phys;
    assign sel_sysrom    = result_q.sel[SEL_SYSROM];
    assign sel_fnrom_int = result_q.sel[SEL_FNINT];
    assign sel_fnrom_ext = result_q.sel[SEL_FNEXT];
    assign sel_io        = result_q.sel[SEL_IO];
    assign sel_ram       = result_q.sel[SEL_RAM];
    assign sel_regs      = result_q.sel[SEL_REGS];

    // R1
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({sel_regs, sel_ram, sel_io, sel_fnrom_ext, sel_fnrom_int, sel_sysrom}));

    generate
        if (REG_OUT) begin : g_lat_chk
            // R2
            out_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (result_q == $past(result_d)));
        end
    endgenerate

    // R3
    reg_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr >= REG_BASE && cpu_addr <= REG_LAST) |-> region_sel[SEL_REGS]);

    // R4
    io_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[CPU_AW-1 -: 4] == 4'hD && !cfg_word[CFG_IO_BIT]) |-> region_sel[SEL_IO]);

    // R8
    shared_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (force_bank0 && cpu_addr[CPU_AW-1:PAGE_W+1] != '0) |-> (ram_phys[PHYS_AW-1] == 1'b0));

    // R9
    zero_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[CPU_AW-1 -: PAGE_W] == '0) |-> (ram_phys == {pg0_ptr, cpu_addr[PAGE_W-1:0]}));
endmodule

// File: tb/bank_xlate_tb.sv
module bank_xlate_tb_top;
    localparam logic [5:0] S_SYS  = 6'b000001;
    localparam logic [5:0] S_FNI  = 6'b000010;
    localparam logic [5:0] S_FNE  = 6'b000100;
    localparam logic [5:0] S_IO   = 6'b001000;
    localparam logic [5:0] S_RAM  = 6'b010000;
    localparam logic [5:0] S_REGS = 6'b100000;

    typedef struct {
        logic [5:0]  sel;
        logic [16:0] phys;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cfg_word = '0;
    logic [7:0]  ramcfg_word = '0;
    logic [8:0]  pg0_ptr = 9'h000;
    logic [8:0]  pg1_ptr = 9'h001;
    logic [16:0] phys_addr;
    logic        sel_sysrom, sel_fnrom_int, sel_fnrom_ext, sel_io, sel_ram, sel_regs;
    logic [5:0]  sel_obs;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    assign sel_obs = {sel_regs, sel_ram, sel_io, sel_fnrom_ext, sel_fnrom_int, sel_sysrom};

    bank_xlate dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cfg_word(cfg_word),
        .ramcfg_word(ramcfg_word), .pg0_ptr(pg0_ptr), .pg1_ptr(pg1_ptr),
        .phys_addr(phys_addr), .sel_sysrom(sel_sysrom), .sel_fnrom_int(sel_fnrom_int),
        .sel_fnrom_ext(sel_fnrom_ext), .sel_io(sel_io), .sel_ram(sel_ram), .sel_regs(sel_regs)
    );

    function automatic exp_t model(input logic [15:0] a, input logic [7:0] c, input logic [7:0] rc,
                                   input logic [8:0] p0, input logic [8:0] p1, input string tag);
        exp_t e;
        logic [1:0] f;
        logic b;
        int unsigned span;
        e.tag = tag;
        e.phys = {1'b0, a};
        e.sel = 6'b0;
        if (a >= 16'hFF00 && a <= 16'hFF04) e.sel = S_REGS;
        else if (a[15:12] == 4'hD && !c[0]) e.sel = S_IO;
        else begin
            if (a < 16'h4000)      f = 2'b11;
            else if (a < 16'h8000) f = c[1] ? 2'b11 : 2'b00;
            else if (a < 16'hC000) f = c[3:2];
            else                   f = c[5:4];
            case (f)
                2'b00: e.sel = S_SYS;
                2'b01: e.sel = S_FNI;
                2'b10: e.sel = S_FNE;
                default: e.sel = S_RAM;
            endcase
        end
        if (e.sel == S_RAM) begin
            case (rc[1:0])
                2'b00: span = 1024;
                2'b01: span = 4096;
                2'b10: span = 8192;
                default: span = 16384;
            endcase
            if (a[15:8] == 8'h00)      e.phys = {p0, a[7:0]};
            else if (a[15:8] == 8'h01) e.phys = {p1, a[7:0]};
            else begin
                b = c[6];
                if (rc[2] && 32'(a) < span) b = 1'b0;
                if (rc[3] && 32'(a) >= 65536 - span) b = 1'b0;
                if ({b, a[15:8]} == p0)      e.phys = {b, 8'h00, a[7:0]};
                else if ({b, a[15:8]} == p1) e.phys = {b, 8'h01, a[7:0]};
                else                         e.phys = {b, a};
            end
        end
        return e;
    endfunction

    // driver: apply one input set and queue its expected result
    task automatic apply(input logic [15:0] a, input logic [7:0] c, input logic [7:0] rc,
                         input logic [8:0] p0, input logic [8:0] p1, input string tag);
        @(negedge clk);
        cpu_addr = a; cfg_word = c; ramcfg_word = rc; pg0_ptr = p0; pg1_ptr = p1;
        sb_q.push_back(model(a, c, rc, p0, p1, tag));
    endtask

    // monitor: registered outputs settle after the edge following the drive
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (sel_obs !== e.sel || phys_addr !== e.phys) begin
                    errors++;
                    $display("FAIL %s: sel=%b phys=%h expected sel=%b phys=%h",
                             e.tag, sel_obs, phys_addr, e.sel, e.phys);
                end
                checks++;
                if ($countones(sel_obs) != 1) begin
                    errors++;
                    $display("FAIL R1: select count=%0d expected 1", $countones(sel_obs));
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R2: reset state
        checks++;
        if (sel_obs !== S_RAM || phys_addr !== 17'h0) begin
            errors++;
            $display("FAIL R2 reset: sel=%b phys=%h expected sel=%b phys=00000", sel_obs, phys_addr, S_RAM);
        end
        rst_n = 1'b1;

        // R6, R7: bottom of memory, default pointers
        apply(16'h2000, 8'h00, 8'h00, 9'h000, 9'h001, "R6 low RAM bank0");
        apply(16'h2000, 8'h40, 8'h00, 9'h000, 9'h001, "R7 bank1 RAM");
        apply(16'h5000, 8'h00, 8'h00, 9'h000, 9'h001, "R6 low sys ROM");
        apply(16'h5000, 8'h42, 8'h00, 9'h000, 9'h001, "R6 R7 low RAM bank1");
        // R5: mid and high field codes
        apply(16'h9000, 8'h00, 8'h00, 9'h000, 9'h001, "R5 mid 00");
        apply(16'h9000, 8'h04, 8'h00, 9'h000, 9'h001, "R5 mid 01");
        apply(16'h9000, 8'h08, 8'h00, 9'h000, 9'h001, "R5 mid 10");
        apply(16'h9000, 8'h4C, 8'h00, 9'h000, 9'h001, "R5 mid 11");
        apply(16'hE000, 8'h10, 8'h00, 9'h000, 9'h001, "R5 high 01");
        apply(16'hE000, 8'h20, 8'h00, 9'h000, 9'h001, "R5 high 10");
        apply(16'hE000, 8'h30, 8'h00, 9'h000, 9'h001, "R5 high 11");
        apply(16'hFFFF, 8'h00, 8'h00, 9'h000, 9'h001, "R5 high 00");
        // R4: I/O window
        apply(16'hD400, 8'h30, 8'h00, 9'h000, 9'h001, "R4 io on");
        apply(16'hD400, 8'h71, 8'h00, 9'h000, 9'h001, "R4 io off ram");
        apply(16'hDFFF, 8'h11, 8'h00, 9'h000, 9'h001, "R4 io off fn");
        apply(16'hCFFF, 8'h00, 8'h00, 9'h000, 9'h001, "R4 below io");
        // R3: register window
        apply(16'hFF00, 8'h7F, 8'h00, 9'h000, 9'h001, "R3 first");
        apply(16'hFF04, 8'h30, 8'h00, 9'h000, 9'h001, "R3 last");
        apply(16'hFF05, 8'h00, 8'h00, 9'h000, 9'h001, "R3 after");
        // R8: common areas, bottom
        apply(16'h03FF, 8'h40, 8'h04, 9'h000, 9'h001, "R8 bottom 1K in");
        apply(16'h0400, 8'h40, 8'h04, 9'h000, 9'h001, "R8 bottom 1K out");
        apply(16'h0FFF, 8'h40, 8'h05, 9'h000, 9'h001, "R8 bottom 4K in");
        apply(16'h1000, 8'h40, 8'h05, 9'h000, 9'h001, "R8 bottom 4K out");
        apply(16'h3FFF, 8'h42, 8'h07, 9'h000, 9'h001, "R8 bottom 16K in");
        apply(16'h4000, 8'h42, 8'h07, 9'h000, 9'h001, "R8 bottom 16K out");
        apply(16'h0800, 8'h40, 8'h00, 9'h000, 9'h001, "R8 disabled");
        // R8: common areas, top
        apply(16'hE000, 8'h7F, 8'h0A, 9'h000, 9'h001, "R8 top 8K in");
        apply(16'hDFFF, 8'h7F, 8'h0A, 9'h000, 9'h001, "R8 top 8K out");
        apply(16'hFC00, 8'h7F, 8'h08, 9'h000, 9'h001, "R8 top 1K in");
        apply(16'hFBFF, 8'h7F, 8'h08, 9'h000, 9'h001, "R8 top 1K out");
        // R9: page redirection
        apply(16'h0012, 8'h00, 8'h00, 9'h137, 9'h001, "R9 page0 to bank1");
        apply(16'h01FF, 8'h40, 8'h00, 9'h137, 9'h080, "R9 page1 to bank0");
        apply(16'h0055, 8'h40, 8'h07, 9'h137, 9'h080, "R9 beats shared");
        // R10: swap back
        apply(16'h3750, 8'h40, 8'h00, 9'h137, 9'h080, "R10 swap pg0");
        apply(16'h3750, 8'h00, 8'h00, 9'h137, 9'h080, "R10 other bank");
        apply(16'h8045, 8'h0C, 8'h00, 9'h137, 9'h080, "R10 swap pg1");
        apply(16'h3750, 8'h40, 8'h07, 9'h037, 9'h137, "R10 shared then swap");
        apply(16'h2222, 8'h40, 8'h00, 9'h122, 9'h122, "R10 pg0 priority");

        repeat (3) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule